// File: doc/BRIEF.md
# Two-Phase Accumulator Processor Core

A small 8-bit processor with separate program and data memories. Its architectural state is an instruction pointer, an accumulator and an index register, all 8 bits wide. Each instruction is 11 bits: a 3-bit opcode in bits [10:8] and an 8-bit operand in bits [7:0]. The operand is usually a data address. Seven of the eight opcodes do work and the eighth does nothing.

The core runs every instruction in exactly two clock cycles. In the fetch cycle the instruction pointer addresses the program memory. That memory registers its output on the rising edge that ends the fetch cycle. In the execute cycle the core decodes that word and drives a data address. The data memory answers combinationally within the same cycle. On the rising edge that ends the execute cycle, the core updates its registers and the data memory takes any write.

The low bits of the accumulator drive an LED port. Programs can therefore show a count or blink a pattern with no other hardware.

Top module: `tac_core`

## Requirements
- R1: A synchronous active-high `rst` clears the instruction pointer, accumulator and index register to 0, and the first cycle after reset is a fetch cycle.
- R2: Cycles alternate fetch, execute, fetch. `imem_addr` equals the instruction pointer, which changes only on the edge that ends an execute cycle. An instruction's results are visible after that edge.
- R3: Opcode 0 adds `mem[(operand + index) mod 256]` to the accumulator, modulo 256.
- R4: Opcode 1 replaces the accumulator with the bitwise NAND of the accumulator and `mem[(operand + index) mod 256]`.
- R5: Opcode 2 loads the accumulator from `mem[(operand + index) mod 256]`.
- R6: Opcode 3 writes the accumulator to `mem[(operand + index) mod 256]` on the edge that ends the execute cycle. `dmem_we` is never high in a fetch cycle.
- R7: Opcode 4 loads the index register from `mem[operand]`; the index is not added to this address.
- R8: Opcode 5 sets the instruction pointer to the operand.
- R9: Opcode 6 sets the instruction pointer to the operand when the accumulator is zero; otherwise the pointer advances by one.
- R10: Opcode 7 leaves the accumulator, the index register and data memory unchanged and advances the instruction pointer by one.
- R11: The instruction pointer wraps from 255 to 0, and the sum operand + index wraps modulo 256.
- R12: `led` always equals the low `LED_W` bits of the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 8 | Program memory address (instruction pointer) |
| imem_data | input | 11 | Registered program memory word |
| dmem_addr | output | 8 | Data memory address |
| dmem_rdata | input | 8 | Data memory read value, combinational from `dmem_addr` |
| dmem_wdata | output | 8 | Data memory write value (accumulator) |
| dmem_we | output | 1 | Data memory write strobe, taken on the rising edge |
| led | output | LED_W | Low bits of the accumulator |
| acc_o | output | 8 | Accumulator value |
| idx_o | output | 8 | Index register value |
| ip_o | output | 8 | Instruction pointer value |

## Verification
After reset is released on a falling edge, the first rising edge completes the fetch of instruction 0. The second rising edge commits its results. The bench therefore waits two rising edges for each instruction and samples the pointer, accumulator, index, LED port and the touched memory byte on the falling edge that follows. A reference model steps one instruction at that point, so the comparison is made after the commit edge and before the next one. Memory effects of a store are read back through the harness memory at the same sampling point.

// File: rtl/tac_pkg.sv
package tac_pkg;
    parameter int WORD_W = 8;
    parameter int OPC_W  = 3;
    localparam int INSN_W = OPC_W + WORD_W;
    localparam int DEPTH  = 1 << WORD_W;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD   = 3'd0,
        OP_NAND  = 3'd1,
        OP_LOAD  = 3'd2,
        OP_STORE = 3'd3,
        OP_LDX   = 3'd4,
        OP_JMP   = 3'd5,
        OP_JZ    = 3'd6,
        OP_NOP   = 3'd7
    } opcode_e;

    typedef enum logic {
        PH_FETCH = 1'b0,
        PH_EXEC  = 1'b1
    } phase_e;

    typedef enum logic [1:0] {
        ALU_ADD  = 2'd0,
        ALU_NAND = 2'd1,
        ALU_PASS = 2'd2
    } alu_sel_e;

    typedef struct packed {
        opcode_e op;
        word_t   arg;
    } insn_t;

    typedef struct packed {
        logic     wr_acc;
        logic     wr_idx;
        logic     wr_mem;
        logic     use_idx;
        logic     br_abs;
        logic     br_zero;
        alu_sel_e alu;
    } ctrl_t;

    function automatic word_t alu_eval(alu_sel_e sel, word_t a, word_t m);
        case (sel)
            ALU_ADD:  return word_t'(a + m);
            ALU_NAND: return ~(a & m);
            default:  return m;
        endcase
    endfunction
endpackage

// File: rtl/tac_phase.sv
module tac_phase
    import tac_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output logic exec
);
    phase_e ph_q;

    always_ff @(posedge clk) begin
        if (rst) ph_q <= PH_FETCH;
        else     ph_q <= (ph_q == PH_FETCH) ? PH_EXEC : PH_FETCH;
    end

    assign exec = (ph_q == PH_EXEC);
endmodule

// File: rtl/tac_decode.sv
module tac_decode
    import tac_pkg::*;
(
    input  insn_t insn,
    output ctrl_t ctrl
);
    always_comb begin
        ctrl = '0;
        ctrl.alu = ALU_PASS;
        case (insn.op)
            OP_ADD:   begin ctrl.wr_acc = 1'b1; ctrl.use_idx = 1'b1; ctrl.alu = ALU_ADD;  end
            OP_NAND:  begin ctrl.wr_acc = 1'b1; ctrl.use_idx = 1'b1; ctrl.alu = ALU_NAND; end
            OP_LOAD:  begin ctrl.wr_acc = 1'b1; ctrl.use_idx = 1'b1; end
            OP_STORE: begin ctrl.wr_mem = 1'b1; ctrl.use_idx = 1'b1; end
            OP_LDX:   ctrl.wr_idx  = 1'b1;
            OP_JMP:   ctrl.br_abs  = 1'b1;
            OP_JZ:    ctrl.br_zero = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/tac_alu.sv
module tac_alu
    import tac_pkg::*;
(
    input  alu_sel_e sel,
    input  word_t    acc,
    input  word_t    mem,
    output word_t    y
);
    assign y = alu_eval(sel, acc, mem);
endmodule

// File: rtl/tac_core.sv
module tac_core
    import tac_pkg::*;
#(
    parameter int LED_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    output logic [WORD_W-1:0] imem_addr,
    input  logic [INSN_W-1:0] imem_data,
    output logic [WORD_W-1:0] dmem_addr,
    input  logic [WORD_W-1:0] dmem_rdata,
    output logic [WORD_W-1:0] dmem_wdata,
    output logic              dmem_we,
    output logic [LED_W-1:0]  led,
    output logic [WORD_W-1:0] acc_o,
    output logic [WORD_W-1:0] idx_o,
    output logic [WORD_W-1:0] ip_o
);
    insn_t insn;
    ctrl_t ctrl;
    logic  exec_ph;
    word_t ip_q, acc_q, idx_q;
    word_t alu_y, ip_next, d_addr;
    logic  take;

    assign insn = insn_t'(imem_data);

    tac_phase u_phase (.clk(clk), .rst(rst), .exec(exec_ph));
    tac_decode u_dec (.insn(insn), .ctrl(ctrl));
    tac_alu u_alu (.sel(ctrl.alu), .acc(acc_q), .mem(dmem_rdata), .y(alu_y));

    assign d_addr  = ctrl.use_idx ? word_t'(insn.arg + idx_q) : insn.arg;
    assign take    = ctrl.br_abs | (ctrl.br_zero & (acc_q == '0));
    assign ip_next = take ? insn.arg : word_t'(ip_q + 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ip_q  <= '0;
            acc_q <= '0;
            idx_q <= '0;
        end else if (exec_ph) begin
            ip_q <= ip_next;
            if (ctrl.wr_acc) acc_q <= alu_y;
            if (ctrl.wr_idx) idx_q <= dmem_rdata;
        end
    end

    assign imem_addr  = ip_q;
    assign dmem_addr  = d_addr;
    assign dmem_wdata = acc_q;
    assign dmem_we    = exec_ph & ctrl.wr_mem;
    assign led        = acc_q[LED_W-1:0];
    assign acc_o      = acc_q;
    assign idx_o      = idx_q;
    assign ip_o       = ip_q;
endmodule

// File: rtl/tac_core_chk.sv
module tac_core_chk
    import tac_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              exec,
    input logic [WORD_W-1:0] ip,
    input logic [WORD_W-1:0] acc,
    input logic [WORD_W-1:0] idx,
    input logic [INSN_W-1:0] imem_data,
    input logic              dmem_we
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (ip == '0 && acc == '0 && idx == '0 && !exec));

    assert_fetch_to_exec_R2: assert property (@(posedge clk) disable iff (rst)
        !exec |=> exec);

    assert_exec_to_fetch_R2: assert property (@(posedge clk) disable iff (rst)
        exec |=> !exec);

    assert_ip_hold_in_fetch_R2: assert property (@(posedge clk) disable iff (rst)
        !exec |=> $stable(ip));

    assert_write_only_exec_R6: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> exec);

    assert_jump_target_R8: assert property (@(posedge clk) disable iff (rst)
        (exec && imem_data[INSN_W-1:WORD_W] == OP_JMP) |=> ip == $past(imem_data[WORD_W-1:0]));

    assert_nop_keeps_state_R10: assert property (@(posedge clk) disable iff (rst)
        (exec && imem_data[INSN_W-1:WORD_W] == OP_NOP)
        |=> ($stable(acc) && $stable(idx) && ip == WORD_W'($past(ip) + 1'b1)));
endmodule

bind tac_core tac_core_chk u_chk (
    .clk(clk), .rst(rst), .exec(exec_ph), .ip(ip_q), .acc(acc_q), .idx(idx_q),
    .imem_data(imem_data), .dmem_we(dmem_we)
);

// File: tb/test_tac_core.sv
`timescale 1ns/1ps
module test_tac_core;
    import tac_pkg::*;
    localparam int LED_W = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [WORD_W-1:0] imem_addr, dmem_addr, dmem_rdata, dmem_wdata;
    logic [WORD_W-1:0] acc_o, idx_o, ip_o;
    logic [INSN_W-1:0] rom_q;
    logic              dmem_we;
    logic [LED_W-1:0]  led;

    logic [INSN_W-1:0] rom [DEPTH];
    logic [WORD_W-1:0] ram [DEPTH];

    always @(posedge clk) rom_q <= rom[imem_addr];
    always @(posedge clk) if (dmem_we) ram[dmem_addr] <= dmem_wdata;
    assign dmem_rdata = ram[dmem_addr];

    tac_core #(.LED_W(LED_W)) i_tac_core (
        .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(rom_q),
        .dmem_addr(dmem_addr), .dmem_rdata(dmem_rdata), .dmem_wdata(dmem_wdata),
        .dmem_we(dmem_we), .led(led), .acc_o(acc_o), .idx_o(idx_o), .ip_o(ip_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    word_t m_ip, m_acc, m_idx;
    word_t mref [DEPTH];

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(logic [OPC_W-1:0] op);
        case (op)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R8";
            3'd6: return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic logic [INSN_W-1:0] mk(int op, int arg);
        return {OPC_W'(op), WORD_W'(arg)};
    endfunction

    task automatic reset_assert();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reset_release();
        for (int i = 0; i < DEPTH; i++) mref[i] = ram[i];
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_ip = '0; m_acc = '0; m_idx = '0;
        chk("R1", "ip after reset", ip_o, 0);
        chk("R1", "acc after reset", acc_o, 0);
        chk("R1", "idx after reset", idx_o, 0);
        chk("R12", "led after reset", led, 0);
    endtask

    task automatic run_insn();
        logic [INSN_W-1:0] w;
        logic [OPC_W-1:0]  op;
        word_t arg, a, old_ip;
        string tg;
        w = rom[m_ip];
        op = w[INSN_W-1:WORD_W];
        arg = w[WORD_W-1:0];
        a = (op == 3'd4) ? arg : word_t'(arg + m_idx);
        tg = tag_of(op);
        old_ip = m_ip;
        @(posedge clk);
        @(negedge clk);
        chk("R2", "ip held through fetch", ip_o, old_ip);
        @(posedge clk);
        @(negedge clk);
        m_ip = word_t'(m_ip + 1'b1);
        case (op)
            3'd0: m_acc = word_t'(m_acc + mref[a]);
            3'd1: m_acc = ~(m_acc & mref[a]);
            3'd2: m_acc = mref[a];
            3'd3: mref[a] = m_acc;
            3'd4: m_idx = mref[a];
            3'd5: m_ip = arg;
            3'd6: if (m_acc == '0) m_ip = arg;
            default: ;
        endcase
        if (old_ip == 8'hFF && op != 3'd5 && op != 3'd6)
            chk("R11", "ip wrap", ip_o, m_ip);
        else
            chk(tg, "ip", ip_o, m_ip);
        chk(tg, "acc", acc_o, m_acc);
        chk(tg, "idx", idx_o, m_idx);
        chk(tg, "mem byte", ram[a], mref[a]);
        chk("R12", "led", led, m_acc[LED_W-1:0]);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h1234_5678);
        for (int i = 0; i < DEPTH; i++) begin rom[i] = '0; ram[i] = '0; end

        // Directed: count 0xFB up to zero, then leave the loop via JZ
        reset_assert();
        for (int i = 0; i < DEPTH; i++) begin rom[i] = mk(7, 0); ram[i] = 8'h00; end
        ram[8'h10] = 8'h01; ram[8'h11] = 8'hFB; ram[8'h12] = 8'h5A;
        rom[0] = mk(2, 8'h11); rom[1] = mk(0, 8'h10); rom[2] = mk(3, 8'h11);
        rom[3] = mk(6, 5);     rom[4] = mk(5, 0);
        rom[5] = mk(4, 8'h10); rom[6] = mk(2, 8'h11); rom[7] = mk(1, 8'h11);
        rom[8] = mk(3, 8'hFF); rom[9] = mk(7, 8'h33); rom[10] = mk(5, 10);
        reset_release();
        for (int i = 0; i < 40; i++) run_insn();
        chk("R6", "counter reached zero", ram[8'h11], 8'h00);

        // Mid-run reset from non-zero state, then a NOP sweep that wraps the pointer (R11)
        reset_assert();
        for (int i = 0; i < DEPTH; i++) rom[i] = mk(7, $urandom_range(255));
        reset_release();
        for (int i = 0; i < 260; i++) run_insn();

        // Random programs, zero-biased data so JZ is taken sometimes
        for (int p = 0; p < 4; p++) begin
            reset_assert();
            for (int i = 0; i < DEPTH; i++) begin
                rom[i] = mk($urandom_range(7), $urandom_range(255));
                ram[i] = ($urandom_range(3) == 0) ? 8'h00 : 8'($urandom_range(255));
            end
            reset_release();
            for (int i = 0; i < 300; i++) run_insn();
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule